// File: doc/BRIEF.md
# Page Strobe Glitch Filter

This block cleans an active-low page-select strobe before it reaches a peripheral's chip select. The processor runs at twice the rate of a slow 50%-duty bus clock. Its clock is stretched to line up with that bus clock, so the address can move while the bus clock is high. This produces false strobe pulses, and a single access can be presented to the device twice. The block runs in the domain of a fast system clock. It brings the bus clock and the strobe in through a synchronizer and drives a clean active-low chip select. It also drives a one-cycle access pulse, so a device whose registers clear on read sees each processor access exactly once.

Two filter modes are available, chosen by a static input. In latch mode, a set/reset latch follows the strobe only while the bus clock is low and holds while it is high. Pulses that settle during the high phase are rejected, while low-phase glitches may pass. In edge mode, the strobe is captured when the bus clock rises, and the select is dropped when the bus clock falls. This gives a fully clean select with a shorter window.

Top module: `page_strobe_filter`

## Requirements
- R1: While rst_ni is low, cs_no is 1 and access_o is 0.
- R2: mode_i = 0 selects latch mode: a synchronized strobe (strobe_ni low) seen while the synchronized bus clock is low asserts cs_no low, and cs_no keeps its value for the whole synchronized high phase.
- R3: In latch mode, a strobe that goes low and returns high entirely within a bus-clock high phase never asserts cs_no and gives no access pulse.
- R4: In latch mode, a strobe glitch entirely within a bus-clock low phase passes to cs_no and counts as one access.
- R5: mode_i = 1 selects edge mode: the strobe is sampled when the synchronized bus clock rises, and cs_no is released when it falls, so a strobe spanning a rising edge gives a select exactly one bus-clock high phase (20 fast cycles in the bench) long, and a strobe not spanning a rising edge gives none.
- R6: A strobe held low across several bus-clock high phases gives exactly one access pulse, even when cs_no asserts more than once.
- R7: access_o lasts one fast-clock cycle, occurs only while cs_no is low, and re-arms only after the strobe has returned high and cs_no is released, so two separate strobes give two pulses.
- R8: bus_clk_i and strobe_ni pass through a synchronizer of SYNC_STAGES flops (default 2) before any decision, with idle reset values (bus clock 0, strobe 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Static mode: 0 latch, 1 edge |
| bus_clk_i | input | 1 | Slow 50%-duty bus clock, asynchronous |
| strobe_ni | input | 1 | Raw active-low page-select strobe |
| cs_no | output | 1 | Cleaned active-low chip select |
| access_o | output | 1 | One-cycle pulse, one per processor access |

## Verification
The hardest case to reach is a single access that the filter presents to the device twice. This needs a strobe held low across more than one bus-clock high phase, so that cs_no asserts again while access_o must stay quiet. The bench drives a free-running bus clock and places strobe edges at chosen phase counts. This lets it hold one strobe over three bus periods, and also confine pulses to a single high or low phase in each mode. A behavioural reference built from queues of past input samples predicts cs_no and access_o on every cycle.

// File: rtl/pstb_pkg.sv
package pstb_pkg;
  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_EDGE  = 1'b1
  } pstb_mode_e;
endpackage

// File: rtl/pstb_sync.sv
module pstb_sync #(
  parameter int unsigned       W       = 2,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pstb_gate_latch.sv
// Follows the request while the bus clock is low, holds while it is high.
module pstb_gate_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic req_i,
  output logic sel_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (!bclk_i) sel_q <= req_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/pstb_edge_cap.sv
// Captures the request on a bus-clock rise, releases on the fall.
module pstb_edge_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic bclk_d_i,
  input  logic req_i,
  output logic sel_o
);
  logic sel_q;
  logic rise, fall;

  assign rise = bclk_i & ~bclk_d_i;
  assign fall = ~bclk_i & bclk_d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= 1'b0;
    else if (rise) sel_q <= req_i;
    else if (fall) sel_q <= 1'b0;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/pstb_oneshot.sv
module pstb_oneshot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic req_i,
  output logic pulse_o
);
  logic armed_q;

  assign pulse_o = sel_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                armed_q <= 1'b1;
    else if (pulse_o)           armed_q <= 1'b0;
    else if (!req_i && !sel_i)  armed_q <= 1'b1; // strobe idle and select released
  end
endmodule

// File: rtl/page_strobe_filter.sv
module page_strobe_filter
  import pstb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic bus_clk_i,
  input  logic strobe_ni,
  output logic cs_no,
  output logic access_o
);
  localparam int unsigned SW = 2;

  logic [SW-1:0] raw, synced;
  logic bclk_s, req_s, bclk_d;
  logic sel_latch, sel_edge, sel;

  assign raw = {bus_clk_i, strobe_ni};

  pstb_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign bclk_s = synced[1];
  assign req_s  = ~synced[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_d <= 1'b0;
    else         bclk_d <= bclk_s;
  end

  pstb_gate_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bclk_i(bclk_s),
    .req_i (req_s),
    .sel_o (sel_latch)
  );

  pstb_edge_cap u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bclk_i  (bclk_s),
    .bclk_d_i(bclk_d),
    .req_i   (req_s),
    .sel_o   (sel_edge)
  );

  assign sel = (pstb_mode_e'(mode_i) == MODE_EDGE) ? sel_edge : sel_latch;

  pstb_oneshot u_shot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .req_i  (req_s),
    .pulse_o(access_o)
  );

  assign cs_no = ~sel;
endmodule

// File: rtl/page_strobe_filter_chk.sv
module page_strobe_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_i,
  input logic cs_no,
  input logic access_o,
  input logic bclk_s,
  input logic bclk_d
);
  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> (cs_no && !access_o));

  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |=> !access_o);

  a_r7_pulse_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |-> !cs_no);

  a_r2_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && $past(!mode_i) && $past(bclk_s)) |-> $stable(cs_no));

  a_r5_edge_high_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !cs_no) |-> bclk_d);
endmodule

bind page_strobe_filter page_strobe_filter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .cs_no   (cs_no),
  .access_o(access_o),
  .bclk_s  (bclk_s),
  .bclk_d  (bclk_d)
);

// File: tb/sim_page_strobe_filter.sv
`timescale 1ns/1ps
module sim_page_strobe_filter;
  logic clk_i = 0, rst_ni = 0, mode_i = 0, bus_clk_i = 0, strobe_ni = 1;
  logic cs_no, access_o;
  int total = 0, bad = 0, cyc = 0, cnt = 0;
  int pulses = 0, cs_cycles = 0;
  bit done = 0;

  page_strobe_filter u0 (.*);

  always #5 clk_i = ~clk_i;

  // free-running bus clock: 20 fast cycles low, 20 high
  always @(negedge clk_i) begin
    cnt = (cnt == 39) ? 0 : cnt + 1;
    bus_clk_i <= (cnt >= 20);
  end

  // reference model: queues of past input samples
  bit hb[$], hs[$];
  bit m_latch, m_edge, m_armed, m_sel;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb = '{0, 0, 0}; hs = '{1, 1, 1};
      m_latch = 0; m_edge = 0; m_armed = 1; m_sel = 0;
    end else begin
      bit bs, bd, rq, pulse;
      bs = hb[1]; bd = hb[2]; rq = !hs[1];
      pulse = m_sel && m_armed;
      if (pulse) m_armed = 0;
      else if (!rq && !m_sel) m_armed = 1;
      if (!bs) m_latch = rq;
      if (bs && !bd) m_edge = rq;
      else if (!bs && bd) m_edge = 0;
      m_sel = mode_i ? m_edge : m_latch;
      hb.push_front(bus_clk_i); void'(hb.pop_back());
      hs.push_front(strobe_ni); void'(hs.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    #2;
    if (rst_ni) begin
      chk("R8 model cs_no", cs_no, !m_sel);
      chk("R7 model access_o", access_o, m_sel && m_armed);
      if (access_o) pulses++;
      if (!cs_no) cs_cycles++;
    end
  end

  task automatic at_cnt(int v);
    do begin @(negedge clk_i); #1; end while (cnt != v);
  endtask

  task automatic clr();
    pulses = 0; cs_cycles = 0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #3;
    chk("R1 reset cs_no", cs_no, 1);
    chk("R1 reset access_o", access_o, 0);
    rst_ni = 1;
    settle();

    // R2 R6: latch mode, strobe held over three bus periods
    clr(); at_cnt(5); strobe_ni = 0;
    repeat (120) @(negedge clk_i);
    at_cnt(5); strobe_ni = 1; settle();
    chk("R6 latch long one pulse", pulses, 1);
    chk("R2 latch cs asserted", cs_cycles > 40, 1);

    // R3: pulse inside high phase rejected
    clr(); at_cnt(22); strobe_ni = 0; at_cnt(30); strobe_ni = 1; settle();
    chk("R3 latch high glitch cs", cs_cycles, 0);
    chk("R3 latch high glitch pulses", pulses, 0);

    // R4: low-phase glitch passes
    clr(); at_cnt(5); strobe_ni = 0; at_cnt(8); strobe_ni = 1; settle();
    chk("R4 latch low glitch passes", cs_cycles > 0, 1);
    chk("R4 latch low glitch pulses", pulses, 1);

    // R5: edge mode, strobe spanning a rising edge
    mode_i = 1; settle();
    clr(); at_cnt(10); strobe_ni = 0; at_cnt(35); strobe_ni = 1; settle();
    chk("R5 edge cs width", cs_cycles, 20);
    chk("R5 edge pulses", pulses, 1);

    // R5: no rising edge spanned
    clr(); at_cnt(22); strobe_ni = 0; at_cnt(30); strobe_ni = 1;
    at_cnt(5); strobe_ni = 0; at_cnt(12); strobe_ni = 1; settle();
    chk("R5 edge no span cs", cs_cycles, 0);
    chk("R5 edge no span pulses", pulses, 0);

    // R6: edge mode long strobe, cs asserts three times
    clr(); at_cnt(10); strobe_ni = 0;
    repeat (100) @(negedge clk_i);
    at_cnt(10); strobe_ni = 1; settle();
    chk("R6 edge cs three windows", cs_cycles, 60);
    chk("R6 edge long one pulse", pulses, 1);

    // R7: two separate strobes give two pulses
    clr();
    at_cnt(10); strobe_ni = 0; at_cnt(30); strobe_ni = 1;
    at_cnt(10); strobe_ni = 0; at_cnt(30); strobe_ni = 1; settle();
    chk("R7 rearm two pulses", pulses, 2);

    mode_i = 0; settle();
    clr();
    at_cnt(2); strobe_ni = 0; at_cnt(10); strobe_ni = 1;
    at_cnt(2); strobe_ni = 0; at_cnt(10); strobe_ni = 1; settle();
    chk("R7 latch rearm two pulses", pulses, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule